// File: doc/BRIEF.md
# Descriptor ring pointer manager

This block keeps the pointers for one circular ring of fixed-size descriptors held in memory. It can act as the producer side of the ring (source mode) or as the consumer side (destination mode). Each pointer is held as a word offset into the ring. The ring holds `NUM_ENTRIES` entries of `ENTRY_WORDS` words each, and the entry count need not be a power of two. Pointers therefore wrap by a compare and a subtract, never by a mask. Each word offset has an entry-index counter beside it, so the entry counts come out with no divide.

A client issues one command per cycle:
- open an access window, which loads the cached copy of the far side's pointer;
- take the next entry;
- peek at the next entry;
- ask how many entries are free or valid, with an optional refresh of the cached pointer;
- in source mode, reap completed entries and post new entries into slots that were reaped;
- close the window, which writes the local pointer out to the far side.

Each command's answer appears on the next cycle. It gives the entry's word offset, a hit flag and, for a count query, the entry count. In source mode one slot always stays empty, so a full ring and an empty ring look different.

Top module: `ring_desc_ptr_mgr`

## Requirements
- R1: After reset, all pointers are zero and every output is zero. A first count query then returns `NUM_ENTRIES-1` in source mode and 0 in destination mode.
- R2: The command is `cmd_op` when `cmd_valid` is high. The codes are: 0 idle, 1 open window, 2 next, 3 peek, 4 count, 5 reap, 6 post-reaped, 7 close window. The response appears on the cycle after the command, with `rsp_valid` high for exactly that cycle. `rsp_hit` and `rsp_offset` are zero whenever the command misses or has no entry to report.
- R3: A pointer advances by `ENTRY_WORDS` words. When the sum reaches `NUM_ENTRIES*ENTRY_WORDS`, that ring size is subtracted. Offsets are always below the ring size.
- R4: In source mode, next hits only if the advanced head differs from the cached tail. On a hit it returns the old head offset and moves both the head and the reap pointer to the advanced head. On a miss nothing moves.
- R5: Peek returns the same hit and offset that next would return, but moves no pointer.
- R6: In source mode, count returns the free entries: `tail-head-1` when tail > head, otherwise `NUM_ENTRIES-head+tail-1`, in entry units.
- R7: In destination mode, next hits only if the local tail differs from the cached head, and it returns the tail offset then advances the tail. Count returns `head-tail` when head >= tail, otherwise `NUM_ENTRIES-tail+head`.
- R8: Open window loads the cached far-side pointer from `remote_ptr`. That pointer is the tail in source mode and the head in destination mode.
- R9: A count with `cmd_sync` high uses `remote_ptr` for the result and stores it as the new cached pointer. With `cmd_sync` low the cached value is used and kept.
- R10: In source mode, reap advances the reap pointer and returns its new offset, but only if the new position is not the cached tail. Otherwise it misses.
- R11: In source mode, post-reaped hits only while the head differs from the reap pointer. It returns the head offset and advances the head.
- R12: Close window pulses `remote_wr_en` for one cycle with `remote_wr_ptr` equal to the local pointer's word offset. `remote_wr_ptr` holds its value until the next close.
- R13: In destination mode, reap and post-reaped always miss and move no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_mode | input | 1 | 1 = producer (source) ring, 0 = consumer (destination) ring; held stable between resets |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_sync | input | 1 | On a count query, refresh the cached pointer from `remote_ptr` |
| remote_ptr | input | OW | Far-side pointer, word offset |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Command found an entry |
| rsp_offset | output | OW | Word offset of the returned entry |
| rsp_count | output | CW | Free (source) or valid (destination) entry count |
| remote_wr_en | output | 1 | Local pointer write-out strobe |
| remote_wr_ptr | output | OW | Local pointer word offset written out |

## Verification
The assertions take for granted that `remote_ptr` is a whole multiple of `ENTRY_WORDS` below the ring size whenever it is sampled. They also assume that `src_mode` changes only while reset is held, and that `cmd_valid` is low during reset. The stimulus writes far-side pointers only as entry index times entry size, and it switches between source and destination mode only inside a reset sequence. Ring contents are never modelled. The expected offsets and counts come from per-entry index arithmetic restated in the bench.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_OPEN  = 3'd1,
    OP_NEXT  = 3'd2,
    OP_PEEK  = 3'd3,
    OP_COUNT = 3'd4,
    OP_REAP  = 3'd5,
    OP_POST  = 3'd6,
    OP_CLOSE = 3'd7
  } ring_op_e;

  // free producer slots, one slot always held back
  function automatic int unsigned src_free(int unsigned tail, int unsigned head,
                                           int unsigned n);
    if (tail > head) return tail - head - 1;
    else             return n - head + tail - 1;
  endfunction

  // entries written by the far side and not yet consumed
  function automatic int unsigned dst_valid(int unsigned head, int unsigned tail,
                                            int unsigned n);
    if (head >= tail) return head - tail;
    else              return n - tail + head;
  endfunction

endpackage

// File: rtl/ring_ptr_adv.sv
// Advances an (index, word offset) pointer pair by one entry, wrapping by
// compare and subtract so that non power-of-two rings work.
module ring_ptr_adv #(
  parameter int ENTRY_WORDS = 3,
  parameter int NUM_ENTRIES = 5,
  parameter int IW = 3,
  parameter int OW = 4
) (
  input  logic [IW-1:0] idx_i,
  input  logic [OW-1:0] off_i,
  output logic [IW-1:0] idx_o,
  output logic [OW-1:0] off_o
);
  localparam int RING_WORDS = ENTRY_WORDS * NUM_ENTRIES;

  logic [OW:0] sum;

  always_comb begin
    sum = {1'b0, off_i} + (OW+1)'(ENTRY_WORDS);
    if (sum >= (OW+1)'(RING_WORDS)) begin
      off_o = OW'(sum - (OW+1)'(RING_WORDS));
      idx_o = '0;
    end else begin
      off_o = OW'(sum);
      idx_o = idx_i + IW'(1);
    end
  end
endmodule

// File: rtl/ring_ptr_count.sv
// Entry count from index pair: free slots (source) or valid entries (destination).
module ring_ptr_count #(
  parameter int NUM_ENTRIES = 5,
  parameter int IW = 3,
  parameter int CW = 3
) (
  input  logic          src_mode,
  input  logic [IW-1:0] local_idx,
  input  logic [IW-1:0] far_idx,
  output logic [CW-1:0] count
);
  import ring_ptr_pkg::*;

  int unsigned raw;

  always_comb begin
    if (src_mode) raw = src_free(32'(far_idx), 32'(local_idx), NUM_ENTRIES);
    else          raw = dst_valid(32'(far_idx), 32'(local_idx), NUM_ENTRIES);
    count = CW'(raw);
  end
endmodule

// File: rtl/ring_desc_ptr_mgr.sv
module ring_desc_ptr_mgr #(
  parameter int ENTRY_WORDS = 3,
  parameter int NUM_ENTRIES = 5,
  parameter int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  parameter int OW = $clog2(ENTRY_WORDS * NUM_ENTRIES),
  parameter int CW = $clog2(NUM_ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_mode,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_sync,
  input  logic [OW-1:0] remote_ptr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [OW-1:0] rsp_offset,
  output logic [CW-1:0] rsp_count,
  output logic          remote_wr_en,
  output logic [OW-1:0] remote_wr_ptr
);
  import ring_ptr_pkg::*;

  // word offset -> entry index, by comparison against each entry start
  function automatic logic [IW-1:0] off_to_idx(logic [OW-1:0] off);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (off == OW'(i * ENTRY_WORDS)) r = IW'(i);
    return r;
  endfunction

  // local pointer: head (source) or tail (destination)
  logic [IW-1:0] loc_idx, loc_idx_n;
  logic [OW-1:0] loc_off, loc_off_n;
  // cached far pointer: tail (source) or head (destination)
  logic [IW-1:0] cache_idx, cache_idx_n;
  // reap pointer (source only)
  logic [IW-1:0] reap_idx, reap_idx_n;
  logic [OW-1:0] reap_off, reap_off_n;

  logic [IW-1:0] loc_nxt_idx, reap_nxt_idx, remote_idx, cnt_far_idx;
  logic [OW-1:0] loc_nxt_off, reap_nxt_off;
  logic [CW-1:0] cnt_val;

  ring_op_e op;
  logic hit, wr;
  logic [OW-1:0] off;
  logic [CW-1:0] cnt;

  // named internal events
  logic ev_reserve_ok, ev_consume_ok, ev_reap_ok, ev_post_ok;

  ring_ptr_adv #(.ENTRY_WORDS(ENTRY_WORDS), .NUM_ENTRIES(NUM_ENTRIES), .IW(IW), .OW(OW))
    u_loc_adv (.idx_i(loc_idx), .off_i(loc_off), .idx_o(loc_nxt_idx), .off_o(loc_nxt_off));

  ring_ptr_adv #(.ENTRY_WORDS(ENTRY_WORDS), .NUM_ENTRIES(NUM_ENTRIES), .IW(IW), .OW(OW))
    u_reap_adv (.idx_i(reap_idx), .off_i(reap_off), .idx_o(reap_nxt_idx), .off_o(reap_nxt_off));

  ring_ptr_count #(.NUM_ENTRIES(NUM_ENTRIES), .IW(IW), .CW(CW))
    u_count (.src_mode(src_mode), .local_idx(loc_idx), .far_idx(cnt_far_idx), .count(cnt_val));

  assign op            = ring_op_e'(cmd_op);
  assign remote_idx    = off_to_idx(remote_ptr);
  assign cnt_far_idx   = cmd_sync ? remote_idx : cache_idx;
  assign ev_reserve_ok = src_mode && (loc_nxt_idx != cache_idx);
  assign ev_consume_ok = !src_mode && (loc_idx != cache_idx);
  assign ev_reap_ok    = src_mode && (reap_nxt_idx != cache_idx);
  assign ev_post_ok    = src_mode && (loc_idx != reap_idx);

  always_comb begin
    loc_idx_n   = loc_idx;
    loc_off_n   = loc_off;
    cache_idx_n = cache_idx;
    reap_idx_n  = reap_idx;
    reap_off_n  = reap_off;
    hit = 1'b0;
    off = '0;
    cnt = '0;
    wr  = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_OPEN: cache_idx_n = remote_idx;
        OP_NEXT: begin
          if (ev_reserve_ok || ev_consume_ok) begin
            hit       = 1'b1;
            off       = loc_off;
            loc_idx_n = loc_nxt_idx;
            loc_off_n = loc_nxt_off;
          end
          if (ev_reserve_ok) begin
            reap_idx_n = loc_nxt_idx;
            reap_off_n = loc_nxt_off;
          end
        end
        OP_PEEK: begin
          if (ev_reserve_ok || ev_consume_ok) begin
            hit = 1'b1;
            off = loc_off;
          end
        end
        OP_COUNT: begin
          cnt = cnt_val;
          if (cmd_sync) cache_idx_n = remote_idx;
        end
        OP_REAP: begin
          if (ev_reap_ok) begin
            hit        = 1'b1;
            off        = reap_nxt_off;
            reap_idx_n = reap_nxt_idx;
            reap_off_n = reap_nxt_off;
          end
        end
        OP_POST: begin
          if (ev_post_ok) begin
            hit       = 1'b1;
            off       = loc_off;
            loc_idx_n = loc_nxt_idx;
            loc_off_n = loc_nxt_off;
          end
        end
        OP_CLOSE: wr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_idx       <= '0;
      loc_off       <= '0;
      cache_idx     <= '0;
      reap_idx      <= '0;
      reap_off      <= '0;
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_offset    <= '0;
      rsp_count     <= '0;
      remote_wr_en  <= 1'b0;
      remote_wr_ptr <= '0;
    end else begin
      loc_idx      <= loc_idx_n;
      loc_off      <= loc_off_n;
      cache_idx    <= cache_idx_n;
      reap_idx     <= reap_idx_n;
      reap_off     <= reap_off_n;
      rsp_valid    <= cmd_valid;
      rsp_hit      <= hit;
      rsp_offset   <= off;
      rsp_count    <= cnt;
      remote_wr_en <= wr;
      if (wr) remote_wr_ptr <= loc_off;
    end
  end
endmodule

// File: rtl/ring_desc_ptr_mgr_chk.sv
module ring_desc_ptr_mgr_chk #(
  parameter int ENTRY_WORDS = 3,
  parameter int NUM_ENTRIES = 5,
  parameter int IW = 3,
  parameter int OW = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          src_mode,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [OW-1:0] rsp_offset,
  input logic [CW-1:0] rsp_count,
  input logic          remote_wr_en,
  input logic [IW-1:0] loc_idx,
  input logic [IW-1:0] cache_idx,
  input logic [IW-1:0] reap_idx
);
  localparam int RING_WORDS = ENTRY_WORDS * NUM_ENTRIES;

  p_resp_follows_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  p_no_resp_without_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid && !rsp_hit);

  p_offset_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_offset < OW'(RING_WORDS));

  p_peek_holds_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd3 |=> $stable(loc_idx) && $stable(reap_idx));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && src_mode |-> rsp_count <= CW'(NUM_ENTRIES - 1));

  p_reap_stops_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && cmd_op == 3'd5) && rsp_hit |-> reap_idx != cache_idx);

  p_write_only_on_close_r12: assert property (@(posedge clk) disable iff (!rst_n)
    remote_wr_en |-> $past(cmd_valid && cmd_op == 3'd7));

  p_dest_ignores_reap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !src_mode && (cmd_op == 3'd5 || cmd_op == 3'd6)
      |=> !rsp_hit && $stable(loc_idx));
endmodule

bind ring_desc_ptr_mgr ring_desc_ptr_mgr_chk #(
  .ENTRY_WORDS(ENTRY_WORDS), .NUM_ENTRIES(NUM_ENTRIES), .IW(IW), .OW(OW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_mode(src_mode), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_offset(rsp_offset), .rsp_count(rsp_count), .remote_wr_en(remote_wr_en),
  .loc_idx(loc_idx), .cache_idx(cache_idx), .reap_idx(reap_idx)
);

// File: tb/test_ring_desc_ptr_mgr.sv
`timescale 1ns/1ps
module test_ring_desc_ptr_mgr;
  localparam int E  = 3;
  localparam int N  = 5;
  localparam int OW = 4;
  localparam int CW = 3;
  localparam int VW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_mode = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic          cmd_sync = 1'b0;
  logic [OW-1:0] remote_ptr = '0;
  logic          rsp_valid, rsp_hit, remote_wr_en;
  logic [OW-1:0] rsp_offset, remote_wr_ptr;
  logic [CW-1:0] rsp_count;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ring_desc_ptr_mgr #(.ENTRY_WORDS(E), .NUM_ENTRIES(N)) i_ring_desc_ptr_mgr (
    .clk(clk), .rst_n(rst_n), .src_mode(src_mode), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_sync(cmd_sync), .remote_ptr(remote_ptr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_offset(rsp_offset),
    .rsp_count(rsp_count), .remote_wr_en(remote_wr_en), .remote_wr_ptr(remote_wr_ptr)
  );

  // {op, sync, far ptr, exp hit, exp offset, exp count, exp write strobe, exp written ptr}
  function automatic logic [VW-1:0] mk(int op, int sy, int rp, int h, int o, int c,
                                       int w, int wp);
    return {3'(op), 1'(sy), 4'(rp), 1'(h), 4'(o), 3'(c), 1'(w), 4'(wp)};
  endfunction

  // source-mode walk; ring of 5 entries x 3 words
  localparam int NV = 27;
  localparam logic [VW-1:0] TBL [NV] = '{
    mk(4,0,0, 0,0,4, 0,0),   // free count after reset
    mk(2,0,0, 1,0,0, 0,0),   // reserve entry 0
    mk(3,0,0, 1,3,0, 0,0),   // peek entry 1
    mk(2,0,0, 1,3,0, 0,0),
    mk(2,0,0, 1,6,0, 0,0),
    mk(2,0,0, 1,9,0, 0,0),
    mk(2,0,0, 0,0,0, 0,0),   // full: one slot kept
    mk(4,0,0, 0,0,0, 0,0),
    mk(7,0,0, 0,0,0, 1,12),  // close window -> head 12
    mk(4,1,9, 0,0,3, 0,12),  // sync tail to entry 3
    mk(5,0,0, 1,0,0, 0,12),  // reap wraps to 0
    mk(5,0,0, 1,3,0, 0,12),
    mk(5,0,0, 1,6,0, 0,12),
    mk(5,0,0, 0,0,0, 0,12),  // reap stops short of tail
    mk(6,0,0, 1,12,0, 0,12), // post reaped
    mk(6,0,0, 1,0,0, 0,12),
    mk(6,0,0, 1,3,0, 0,12),
    mk(6,0,0, 0,0,0, 0,12),  // head meets reap
    mk(1,0,0, 0,0,0, 0,12),  // open: tail 0
    mk(4,0,0, 0,0,2, 0,12),
    mk(3,0,0, 1,6,0, 0,12),
    mk(7,0,0, 0,0,0, 1,6),
    mk(1,0,12, 0,0,0, 0,6),  // open: tail entry 4
    mk(4,0,0, 0,0,1, 0,6),   // tail > head branch
    mk(2,0,0, 1,6,0, 0,6),
    mk(2,0,0, 0,0,0, 0,6),
    mk(4,0,0, 0,0,0, 0,6)
  };

  function automatic string tag_of(int op, int sy);
    case (op)
      1: return "R8";
      2: return "R4 R3";
      3: return "R5";
      4: return sy ? "R9" : "R6";
      5: return "R10";
      6: return "R11";
      7: return "R12";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    src_mode = mode;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "rsp_valid", rsp_valid, 0);
    check("R1", "rsp_offset", rsp_offset, 0);
    check("R1", "rsp_count", rsp_count, 0);
    check("R1", "remote_wr_en", remote_wr_en, 0);
    check("R1", "remote_wr_ptr", remote_wr_ptr, 0);
  endtask

  // drives one command, samples at the next falling edge
  task automatic run(logic [VW-1:0] v, string tag);
    int op = int'(v[20:18]);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_op     = v[20:18];
    cmd_sync   = v[17];
    remote_ptr = v[16:13];
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_sync  = 1'b0;
    check("R2", "rsp_valid", rsp_valid, 1);
    check(tag, "rsp_hit", rsp_hit, int'(v[12]));
    check(tag, "rsp_offset", rsp_offset, int'(v[11:8]));
    if (op == 4) check(tag, "rsp_count", rsp_count, int'(v[7:5]));
    check(tag, "remote_wr_en", remote_wr_en, int'(v[4]));
    check(tag, "remote_wr_ptr", remote_wr_ptr, int'(v[3:0]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: source reset state, then the table walk
    do_reset(1'b1);
    for (int i = 0; i < NV; i++)
      run(TBL[i], tag_of(int'(TBL[i][20:18]), int'(TBL[i][17])));

    // R2: response strobe lasts one cycle
    @(negedge clk);
    check("R2", "rsp_valid idle", rsp_valid, 0);

    // destination mode, directed
    do_reset(1'b0);
    run(mk(4,0,0, 0,0,0, 0,0), "R1 R7");   // empty after reset
    run(mk(2,0,0, 0,0,0, 0,0), "R7");
    run(mk(3,0,0, 0,0,0, 0,0), "R5 R7");
    run(mk(1,0,9, 0,0,0, 0,0), "R8");      // head = entry 3
    run(mk(4,0,0, 0,0,3, 0,0), "R7");
    run(mk(2,0,0, 1,0,0, 0,0), "R7");
    run(mk(3,0,0, 1,3,0, 0,0), "R5");
    run(mk(2,0,0, 1,3,0, 0,0), "R7");
    run(mk(2,0,0, 1,6,0, 0,0), "R7");
    run(mk(2,0,0, 0,0,0, 0,0), "R7");      // drained
    run(mk(5,0,0, 0,0,0, 0,0), "R13");
    run(mk(6,0,0, 0,0,0, 0,0), "R13");
    run(mk(7,0,0, 0,0,0, 1,9), "R13 R12"); // tail unmoved by reap/post
    run(mk(4,1,3, 0,0,3, 0,9), "R9 R7");   // head entry 1, wrapped
    run(mk(2,0,0, 1,9,0, 0,9), "R7");
    run(mk(2,0,0, 1,12,0, 0,9), "R7 R3");
    run(mk(2,0,0, 1,0,0, 0,9), "R7 R3");   // wrapped to 0
    run(mk(2,0,0, 0,0,0, 0,9), "R7");
    run(mk(4,0,0, 0,0,0, 0,9), "R9");      // cached head kept
    run(mk(7,0,0, 0,0,0, 1,3), "R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule